// File: doc/BRIEF.md
# Fetch Address Sequencer with Hardware Loop

This block generates the instruction fetch address for a pipelined processor. Each cycle the fetch stage reads the word at the current address, and the block then picks the next one. A taken branch reported by the execute stage comes first. Next, when the hardware loop is armed and the current address equals the loop's last address, the block wraps back to the loop's first address. In every other case it steps to the following word.

The hardware loop has a first address, a last address and a wrap count. All three are loaded through a single write strobe, which also arms the loop. Each wrap lowers the count by one. When the last address is reached with the count already at zero, fetch falls through to the next word and the loop disarms. A loop whose first and last addresses are equal repeats a single instruction. A stall from the pipeline interlock freezes the address and all loop state for that cycle.

Top module: `pc_seq`

## Requirements
- R1: While reset is asserted, `pc` equals RESET_VEC (default 0x0100), `rpt_on` is 0 and `rpt_cnt` is 0.
- R2: In a cycle where `stall` is 1, `pc`, `rpt_on`, `rpt_cnt` and the loop bounds keep their values. A branch or loop load presented in that cycle is dropped.
- R3: When `stall` is 0 and `br_take` is 1, the next `pc` is `br_target`. This holds even at the loop's last address while the loop is armed.
- R4: A taken branch leaves `rpt_on` and `rpt_cnt` unchanged.
- R5: When the loop is armed, `pc` equals the last address and `rpt_cnt` is nonzero (with no branch or stall), the next `pc` is the first address and `rpt_cnt` drops by one.
- R6: When the loop is armed, `pc` equals the last address and `rpt_cnt` is zero (with no branch or stall), the next `pc` is the last address plus one and `rpt_on` clears.
- R7: Otherwise the next `pc` is `pc`+1, modulo 2^AW, so 0xFFFF is followed by 0x0000.
- R8: A `rpt_load` cycle that is not stalled stores the first address, last address and count, and sets `rpt_on`. The address step taken in that same cycle follows the loop state from before the load.
- R9: With equal first and last addresses and count N, that address is presented N+1 times in a row, and then fetch moves to the next word.
- R10: When the loop is disarmed, reaching the old last address causes no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Interlock hold |
| br_take | input | 1 | Execute stage branch taken |
| br_target | input | AW | Branch destination |
| rpt_load | input | 1 | Load loop registers and arm the loop |
| rpt_first | input | AW | Loop first address |
| rpt_last | input | AW | Loop last address |
| rpt_count | input | CW | Number of wraps |
| pc | output | AW | Current fetch address |
| rpt_on | output | 1 | Loop armed |
| rpt_cnt | output | CW | Remaining wraps |

## Verification
Every result is registered and appears exactly one clock edge after the cycle in which its inputs were presented. This applies to the new address, the count decrement, the disarm and the load. The bench changes inputs 2 ns after a rising edge and then waits for the next rising edge. It checks 2 ns after that edge, so each check sees the effect of exactly one cycle's inputs. The wrap, fall-through and single-instruction sequences are traced one cycle at a time against expected addresses worked out in advance.

// File: rtl/pc_seq.sv
module pc_seq #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter logic [AW-1:0] RESET_VEC = 'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          br_take,
  input  logic [AW-1:0] br_target,
  input  logic          rpt_load,
  input  logic [AW-1:0] rpt_first,
  input  logic [AW-1:0] rpt_last,
  input  logic [CW-1:0] rpt_count,
  output logic [AW-1:0] pc,
  output logic          rpt_on,
  output logic [CW-1:0] rpt_cnt
);
  logic [AW-1:0] loop_start, loop_end;

  wire at_end = rpt_on && (pc == loop_end);
  wire wrap   = at_end && (rpt_cnt != '0);
  wire leave  = at_end && (rpt_cnt == '0);

  wire [AW-1:0] pc_next = br_take ? br_target :
                          wrap    ? loop_start : pc + AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc         <= RESET_VEC;
      rpt_on     <= 1'b0;
      rpt_cnt    <= '0;
      loop_start <= '0;
      loop_end   <= '0;
    end else if (!stall) begin
      pc <= pc_next;
      if (rpt_load) begin
        loop_start <= rpt_first;
        loop_end   <= rpt_last;
        rpt_cnt    <= rpt_count;
        rpt_on     <= 1'b1;
      end else if (!br_take) begin
        if (wrap)  rpt_cnt <= rpt_cnt - CW'(1);
        if (leave) rpt_on  <= 1'b0;
      end
    end
  end
endmodule

module pc_seq_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          br_take,
  input logic [AW-1:0] br_target,
  input logic          rpt_load,
  input logic [AW-1:0] pc,
  input logic          rpt_on,
  input logic [CW-1:0] rpt_cnt,
  input logic [AW-1:0] loop_start,
  input logic [AW-1:0] loop_end
);
  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pc) && $stable(rpt_on) && $stable(rpt_cnt) && $stable(loop_end));

  assert_branch_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && br_take) |=> pc == $past(br_target));

  assert_branch_keeps_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && br_take && !rpt_load) |=> $stable(rpt_on) && $stable(rpt_cnt));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !br_take && rpt_on && pc == loop_end && rpt_cnt != '0)
    |=> pc == $past(loop_start));

  assert_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !br_take && !rpt_load && rpt_on && pc == loop_end && rpt_cnt == '0)
    |=> !rpt_on && pc == $past(loop_end) + AW'(1));

  assert_increment_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !br_take && !rpt_on) |=> pc == $past(pc) + AW'(1));

  assert_load_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && rpt_load) |=> rpt_on);
endmodule

bind pc_seq pc_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .br_take(br_take),
  .br_target(br_target), .rpt_load(rpt_load), .pc(pc), .rpt_on(rpt_on),
  .rpt_cnt(rpt_cnt), .loop_start(loop_start), .loop_end(loop_end)
);

// File: tb/pc_seq_tb.sv
module pc_seq_tb;
  logic        clk = 0, rst_n = 0;
  logic        stall = 0, br_take = 0, rpt_load = 0;
  logic [15:0] br_target = 0, rpt_first = 0, rpt_last = 0, rpt_count = 0;
  logic [15:0] pc, rpt_cnt;
  logic        rpt_on;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  pc_seq u_dut (.clk(clk), .rst_n(rst_n), .stall(stall), .br_take(br_take),
    .br_target(br_target), .rpt_load(rpt_load), .rpt_first(rpt_first),
    .rpt_last(rpt_last), .rpt_count(rpt_count), .pc(pc), .rpt_on(rpt_on),
    .rpt_cnt(rpt_cnt));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic st, logic br, logic [15:0] tgt, logic ld,
                     logic [15:0] s, logic [15:0] e, logic [15:0] c);
    stall = st; br_take = br; br_target = tgt;
    rpt_load = ld; rpt_first = s; rpt_last = e; rpt_count = c;
    @(posedge clk); #2;
    stall = 0; br_take = 0; rpt_load = 0;
  endtask

  task automatic idle();          cyc(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic jump(logic [15:0] t); cyc(0, 1, t, 0, 0, 0, 0); endtask
  task automatic load(logic [15:0] s, logic [15:0] e, logic [15:0] c);
    cyc(0, 0, 0, 1, s, e, c);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (2) @(posedge clk); #2;
    chk("R1 pc", pc, 16'h0100);
    chk("R1 rpt_on", rpt_on, 0);
    chk("R1 rpt_cnt", rpt_cnt, 0);
    rst_n = 1;
  endtask

  task automatic t_increment();
    for (int i = 1; i <= 3; i++) begin
      idle(); chk("R7 step", pc, 16'h0100 + i);
    end
  endtask

  task automatic t_block();
    jump(16'h0200); chk("R3 target", pc, 16'h0200);
    load(16'h0201, 16'h0203, 1);
    chk("R8 pc", pc, 16'h0201); chk("R8 on", rpt_on, 1); chk("R8 cnt", rpt_cnt, 1);
    idle(); idle(); chk("R7 in loop", pc, 16'h0203);
    idle(); chk("R5 wrap pc", pc, 16'h0201); chk("R5 cnt", rpt_cnt, 0);
    idle(); idle(); idle();
    chk("R6 exit pc", pc, 16'h0204); chk("R6 off", rpt_on, 0);
    idle(); chk("R7 after exit", pc, 16'h0205);
  endtask

  task automatic t_load_old_state();
    load(16'h0300, 16'h0205, 0);
    chk("R8 old state step", pc, 16'h0206); chk("R8 armed", rpt_on, 1);
    jump(16'h0205); chk("R3 to end", pc, 16'h0205); chk("R4 armed", rpt_on, 1);
    idle(); chk("R6 zero count pc", pc, 16'h0206); chk("R6 disarm", rpt_on, 0);
  endtask

  task automatic t_single();
    load(16'h0207, 16'h0207, 2); chk("R9 first", pc, 16'h0207);
    idle(); chk("R9 second", pc, 16'h0207); chk("R9 cnt", rpt_cnt, 1);
    idle(); chk("R9 third", pc, 16'h0207); chk("R9 cnt0", rpt_cnt, 0);
    idle(); chk("R9 leave", pc, 16'h0208); chk("R9 off", rpt_on, 0);
  endtask

  task automatic t_stall();
    load(16'h0209, 16'h020A, 3); chk("R8 pc", pc, 16'h0209);
    for (int i = 0; i < 2; i++) begin
      cyc(1, 1, 16'h0400, 1, 16'h0400, 16'h0401, 9);
      chk("R2 pc", pc, 16'h0209); chk("R2 cnt", rpt_cnt, 3);
    end
    idle(); chk("R7 pc", pc, 16'h020A);
    idle(); chk("R2 old bounds wrap", pc, 16'h0209); chk("R5 cnt", rpt_cnt, 2);
    idle(); cyc(1, 0, 0, 0, 0, 0, 0);
    chk("R2 hold at end", pc, 16'h020A); chk("R2 cnt held", rpt_cnt, 2);
    idle(); chk("R5 wrap", pc, 16'h0209); chk("R5 cnt", rpt_cnt, 1);
  endtask

  task automatic t_branch_in_loop();
    idle(); chk("R7 pc", pc, 16'h020A);
    jump(16'h0500); chk("R3 over wrap", pc, 16'h0500);
    chk("R4 on", rpt_on, 1); chk("R4 cnt", rpt_cnt, 1);
    jump(16'h020A);
    idle(); chk("R5 wrap", pc, 16'h0209); chk("R5 cnt", rpt_cnt, 0);
    idle(); idle(); chk("R6 exit", pc, 16'h020B); chk("R6 off", rpt_on, 0);
    jump(16'h020A); idle(); chk("R10 no wrap", pc, 16'h020B);
  endtask

  task automatic t_rollover();
    jump(16'hFFFF); idle(); chk("R7 rollover", pc, 16'h0000);
  endtask

  initial begin
    t_reset(); t_increment(); t_block(); t_load_old_state();
    t_single(); t_stall(); t_branch_in_loop(); t_rollover();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule